// File: doc/BRIEF.md
# Signed-Word Load Executor

This block carries out one 64-bit load instruction that fetches a 32-bit word from memory, widens it with sign extension and places it in a destination register. A 32-bit instruction word arrives on a valid/ready input. The block recognises three addressing variants: an indexed variant that updates the base after the access, an indexed variant that updates the base before the access, and a variant with a scaled, unsigned displacement that leaves the base untouched. It reads the base from the general register file or, for base index 31, from the stack pointer, and forms the effective address.

A single 4-byte read goes out on a valid/ready request port. The returned word comes back on a valid/ready response port. On the cycle the response is accepted, the block drives two register write ports: one for the destination and one for the updated base. Instruction words it does not recognise raise an undefined-instruction pulse. A misaligned stack-pointer base raises an alignment-fault pulse. In both cases no memory or register traffic follows. When an indexed variant names the same general register as base and destination, a parameter picks the outcome.

Top module: `sw_load_unit`

## Requirements
- R1: Post-update variant (bits[31:21]=10111000100, bits[11:10]=01, disp9=bits[20:12], base index bits[9:5], dest index bits[4:0]): memory is read at the unmodified base. The base is then written with base plus the sign-extended disp9.
- R2: Pre-update variant (same fixed bits and fields, bits[11:10]=11): memory is read at base plus the sign-extended disp9. That same address is written back to the base. Displacements span -256 to 255.
- R3: Scaled variant (bits[31:22]=1011100110, disp12=bits[21:10]): memory is read at base plus disp12 times 4, which spans 0 to 16380. No base write occurs.
- R4: The 32-bit response word, sign-extended to 64 bits, appears on the destination write port with the destination index. This happens in the cycle the response is accepted.
- R5: A destination index of 31 names the zero register, so no destination write is asserted.
- R6: Base index 31 selects the stack pointer as the base. Any base update is then flagged as a stack-pointer write.
- R7: With base index 31 and a stack pointer whose low 4 bits are not zero, `align_fault_o` pulses in the cycle after acceptance. No request is issued and no write occurs.
- R8: A word matching none of the three variants makes `undef_o` pulse in the cycle after acceptance. No request is issued and no write occurs.
- R9: If an indexed variant has equal base and destination indices other than 31, the parameter `OVL_POLICY` decides the outcome. SUPPRESS, the default, performs the destination write only. UNKNOWN writes `WB_JUNK` to the base. UNDEF raises `undef_o`. NOP ends the instruction with no activity.
- R10: A memory request appears in the cycle after acceptance. It holds valid and its address stable until accepted, and exactly one is issued per load.
- R11: `in_ready` is high only while no instruction is in flight. `mem_rsp_ready` is high only after the request has been accepted and until the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Block idle, will accept |
| in_insn | input | 32 | Instruction word |
| gpr_raddr | output | 5 | Register-file read index (base field of `in_insn`) |
| gpr_rdata | input | 64 | Register-file read data, combinational |
| sp_value | input | 64 | Current stack pointer |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Byte address of the 4-byte read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block waiting for read data |
| mem_rsp_data | input | 32 | Read data word |
| dst_we | output | 1 | Destination write enable |
| dst_idx | output | 5 | Destination register index |
| dst_data | output | 64 | Sign-extended load result |
| base_we | output | 1 | Base update enable |
| base_to_sp | output | 1 | Base update targets the stack pointer |
| base_idx | output | 5 | Base register index |
| base_data | output | 64 | New base value |
| undef_o | output | 1 | Undefined-instruction pulse |
| align_fault_o | output | 1 | Stack-pointer alignment fault pulse |

## Verification
The hardest case to reach from the ports is the stack-pointer base with an update followed by a misaligned stack pointer. A fault only appears if an earlier instruction left the stack pointer with nonzero low bits. The random stream therefore mixes base index 31 with odd displacements, so that pre- and post-update writebacks move the stack pointer off alignment and later loads through it must fault. The equal-index case is forced by directed words and by a random draw that copies the base field into the destination field. Request and response stalls of random length check that the address holds steady and that both writes wait for the response.

// File: rtl/slu_pkg.sv
// Package: shared types for the signed-word load executor.
// Assumes a 32-bit instruction word and 5-bit register indices.
package slu_pkg;

    typedef enum logic [1:0] {
        OVL_SUPPRESS,
        OVL_UNKNOWN,
        OVL_UNDEF,
        OVL_NOP
    } ovl_policy_e;

    typedef enum logic [1:0] {
        FORM_NONE,
        FORM_POST,
        FORM_PRE,
        FORM_UOFF
    } form_e;

    typedef struct packed {
        form_e       form;
        logic [8:0]  disp9;
        logic [11:0] disp12;
        logic [4:0]  rn;
        logic [4:0]  rt;
    } dec_t;

    localparam logic [4:0] IDX_SP_ZR = 5'd31;

endpackage

// File: rtl/slu_decode.sv
// Module: slu_decode
// Classifies an instruction word into one of the three load variants
// (or none) and extracts its fields. Purely combinational.
module slu_decode
    import slu_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);

    // Match fixed opcode bits and slice the operand fields.
    always_comb begin
        dec.disp9  = insn[20:12];
        dec.disp12 = insn[21:10];
        dec.rn     = insn[9:5];
        dec.rt     = insn[4:0];
        dec.form   = FORM_NONE;
        if (insn[31:22] == 10'b1011100110)
            dec.form = FORM_UOFF;
        else if (insn[31:21] == 11'b10111000100 && insn[11:10] == 2'b01)
            dec.form = FORM_POST;
        else if (insn[31:21] == 11'b10111000100 && insn[11:10] == 2'b11)
            dec.form = FORM_PRE;
    end

endmodule

// File: rtl/slu_agen.sv
// Module: slu_agen
// Forms the displacement, the memory address and the base update value.
// Assumes XLEN >= 32. Purely combinational.
module slu_agen
    import slu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  form_e            form,
    input  logic [8:0]       disp9,
    input  logic [11:0]      disp12,
    input  logic [XLEN-1:0]  base,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  upd_addr,
    output logic             upd_en
);

    localparam int S9_PAD  = XLEN - 9;
    localparam int U12_PAD = XLEN - 14;

    logic [XLEN-1:0] disp;
    logic [XLEN-1:0] sum;

    // Pick signed 9-bit or scaled unsigned 12-bit displacement.
    always_comb begin
        if (form == FORM_UOFF)
            disp = {{U12_PAD{1'b0}}, disp12, 2'b00};
        else
            disp = {{S9_PAD{disp9[8]}}, disp9};
    end

    assign sum = base + disp;

    // Post-update reads at the raw base; the others read at the sum.
    always_comb begin
        mem_addr = (form == FORM_POST) ? base : sum;
        upd_addr = sum;
        upd_en   = (form == FORM_POST) || (form == FORM_PRE);
    end

endmodule

// File: rtl/sw_load_unit.sv
// Module: sw_load_unit (top)
// Executes one signed-word load: accept, decode, check, issue a 4-byte
// read, then write destination and base on the response cycle.
// Assumes gpr_rdata is a combinational read of gpr_raddr and that
// sp_value is stable while an instruction is offered.
module sw_load_unit
    import slu_pkg::*;
#(
    parameter int               XLEN       = 64,
    parameter int               SP_ALIGN_W = 4,
    parameter ovl_policy_e      OVL_POLICY = OVL_SUPPRESS,
    parameter logic [XLEN-1:0]  WB_JUNK    = {XLEN{1'b1}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_insn,
    output logic [4:0]       gpr_raddr,
    input  logic [XLEN-1:0]  gpr_rdata,
    input  logic [XLEN-1:0]  sp_value,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [XLEN-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    output logic             mem_rsp_ready,
    input  logic [31:0]      mem_rsp_data,
    output logic             dst_we,
    output logic [4:0]       dst_idx,
    output logic [XLEN-1:0]  dst_data,
    output logic             base_we,
    output logic             base_to_sp,
    output logic [4:0]       base_idx,
    output logic [XLEN-1:0]  base_data,
    output logic             undef_o,
    output logic             align_fault_o
);

    localparam int SEXT_W = XLEN - 32;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} state_e;

    state_e          state_q;
    dec_t            dec;
    logic [XLEN-1:0] base_val;
    logic [XLEN-1:0] agen_mem;
    logic [XLEN-1:0] agen_upd;
    logic            agen_upd_en;
    logic            accept;
    logic            overlap;
    logic            is_undef;
    logic            is_nop;
    logic            misalign;
    logic            go_load;
    logic            rsp_fire;

    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] upd_q;
    logic [4:0]      rt_q;
    logic [4:0]      rn_q;
    logic            upd_en_q;
    logic            upd_sp_q;

    slu_decode u_decode (
        .insn (in_insn),
        .dec  (dec)
    );

    slu_agen #(.XLEN(XLEN)) u_agen (
        .form     (dec.form),
        .disp9    (dec.disp9),
        .disp12   (dec.disp12),
        .base     (base_val),
        .mem_addr (agen_mem),
        .upd_addr (agen_upd),
        .upd_en   (agen_upd_en)
    );

    assign gpr_raddr = dec.rn;
    assign base_val  = (dec.rn == IDX_SP_ZR) ? sp_value : gpr_rdata;
    assign in_ready  = (state_q == ST_IDLE);
    assign accept    = in_valid && in_ready;

    // Classify the offered instruction: undefined, no-op, fault or load.
    always_comb begin
        overlap  = agen_upd_en && (dec.rn == dec.rt) && (dec.rn != IDX_SP_ZR);
        is_undef = (dec.form == FORM_NONE) || (overlap && OVL_POLICY == OVL_UNDEF);
        is_nop   = overlap && (OVL_POLICY == OVL_NOP);
        misalign = (dec.rn == IDX_SP_ZR) && (|sp_value[SP_ALIGN_W-1:0]);
        go_load  = !is_undef && !is_nop && !misalign;
    end

    // Sequence the request and response phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (accept && go_load) state_q <= ST_REQ;
                ST_REQ:  if (mem_req_ready)     state_q <= ST_RSP;
                ST_RSP:  if (mem_rsp_valid)     state_q <= ST_IDLE;
                default:                        state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the address, indices and base update on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            upd_q    <= '0;
            rt_q     <= '0;
            rn_q     <= '0;
            upd_en_q <= 1'b0;
            upd_sp_q <= 1'b0;
        end else if (accept) begin
            addr_q   <= agen_mem;
            upd_q    <= (overlap && OVL_POLICY == OVL_UNKNOWN) ? WB_JUNK : agen_upd;
            rt_q     <= dec.rt;
            rn_q     <= dec.rn;
            upd_en_q <= agen_upd_en && !(overlap && OVL_POLICY == OVL_SUPPRESS);
            upd_sp_q <= (dec.rn == IDX_SP_ZR);
        end
    end

    // One-cycle exception pulses following acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            undef_o       <= 1'b0;
            align_fault_o <= 1'b0;
        end else begin
            undef_o       <= accept && is_undef;
            align_fault_o <= accept && !is_undef && !is_nop && misalign;
        end
    end

    assign mem_req_valid = (state_q == ST_REQ);
    assign mem_req_addr  = addr_q;
    assign mem_rsp_ready = (state_q == ST_RSP);
    assign rsp_fire      = mem_rsp_ready && mem_rsp_valid;

    assign dst_we     = rsp_fire && (rt_q != IDX_SP_ZR);
    assign dst_idx    = rt_q;
    assign dst_data   = {{SEXT_W{mem_rsp_data[31]}}, mem_rsp_data};
    assign base_we    = rsp_fire && upd_en_q;
    assign base_to_sp = upd_sp_q;
    assign base_idx   = rn_q;
    assign base_data  = upd_q;

endmodule

// File: rtl/slu_checker.sv
// Module: slu_checker
// Protocol and sequencing properties of sw_load_unit, bound to every
// instance. Observes ports only.
module slu_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic [31:0]     in_insn,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [XLEN-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            mem_rsp_ready,
    input logic            dst_we,
    input logic [4:0]      dst_idx,
    input logic            base_we,
    input logic            undef_o,
    input logic            align_fault_o
);

    logic known_word;

    // Independent recognition of the three instruction patterns.
    always_comb begin
        casez (in_insn)
            32'b1011100110??????????????????????: known_word = 1'b1;
            32'b10111000100?????????01??????????: known_word = 1'b1;
            32'b10111000100?????????11??????????: known_word = 1'b1;
            default:                              known_word = 1'b0;
        endcase
    end

    assert_undef_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !known_word) |=> undef_o);

    assert_undef_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> !mem_req_valid && in_ready);

    assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault_o |-> !mem_req_valid && in_ready && !undef_o);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

    assert_req_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || mem_rsp_ready) |-> !in_ready);

    assert_rsp_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rsp_ready) |-> $past(mem_req_valid && mem_req_ready));

    assert_dst_on_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> mem_rsp_valid && mem_rsp_ready);

    assert_base_on_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |-> mem_rsp_valid && mem_rsp_ready);

    assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> dst_idx != 5'd31);

endmodule

bind sw_load_unit slu_checker #(.XLEN(XLEN)) u_slu_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_insn       (in_insn),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .dst_we        (dst_we),
    .dst_idx       (dst_idx),
    .base_we       (base_we),
    .undef_o       (undef_o),
    .align_fault_o (align_fault_o)
);

// File: tb/sw_load_unit_bench.sv
// Bench: random and directed instruction words against a register-file
// and stack-pointer model kept in the bench; default overlap policy.
module sw_load_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_insn = '0;
    logic [4:0]  gpr_raddr;
    logic [63:0] gpr_rdata;
    logic [63:0] sp_value;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic [31:0] mem_rsp_data = '0;
    logic        dst_we;
    logic [4:0]  dst_idx;
    logic [63:0] dst_data;
    logic        base_we;
    logic        base_to_sp;
    logic [4:0]  base_idx;
    logic [63:0] base_data;
    logic        undef_o;
    logic        align_fault_o;

    logic [63:0] regs [32];
    logic [63:0] sp_m;
    int          checks = 0;
    int          failures = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    assign gpr_rdata = (gpr_raddr == 5'd31) ? 64'd0 : regs[gpr_raddr];
    assign sp_value  = sp_m;

    sw_load_unit u_sw_load_unit (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn),
        .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata), .sp_value(sp_value),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
        .mem_rsp_data(mem_rsp_data),
        .dst_we(dst_we), .dst_idx(dst_idx), .dst_data(dst_data),
        .base_we(base_we), .base_to_sp(base_to_sp), .base_idx(base_idx),
        .base_data(base_data),
        .undef_o(undef_o), .align_fault_o(align_fault_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 0 none, 1 post-update, 2 pre-update, 3 scaled
    function automatic int classify(input logic [31:0] w);
        casez (w)
            32'b1011100110??????????????????????: return 3;
            32'b10111000100?????????01??????????: return 1;
            32'b10111000100?????????11??????????: return 2;
            default:                              return 0;
        endcase
    endfunction

    function automatic logic [31:0] mk_idx(input bit pre, input logic [8:0] d,
                                           input logic [4:0] rn, input logic [4:0] rt);
        return {11'b10111000100, d, pre ? 2'b11 : 2'b01, rn, rt};
    endfunction

    function automatic logic [31:0] mk_sc(input logic [11:0] d,
                                          input logic [4:0] rn, input logic [4:0] rt);
        return {10'b1011100110, d, rn, rt};
    endfunction

    task automatic run_insn(input logic [31:0] insn);
        int          fm;
        logic [4:0]  rn;
        logic [4:0]  rt;
        logic [63:0] base;
        logic [63:0] off;
        logic [63:0] ea;
        logic [63:0] maddr;
        logic [63:0] sx;
        logic [31:0] word;
        bit          wbk;
        bit          ovl;
        bit          und;
        bit          flt;
        bit          exp_bw;
        string       tag;
        fm   = classify(insn);
        rn   = insn[9:5];
        rt   = insn[4:0];
        base = (rn == 5'd31) ? sp_m : regs[rn];
        off  = (fm == 3) ? (64'(insn[21:10]) * 64'd4) : 64'($signed(insn[20:12]));
        ea   = base + off;
        maddr = (fm == 1) ? base : ea;
        wbk  = (fm == 1) || (fm == 2);
        ovl  = wbk && (rn == rt) && (rn != 5'd31);
        und  = (fm == 0);
        flt  = !und && (rn == 5'd31) && (sp_m[3:0] != 4'd0);
        tag  = (fm == 1) ? "R1" : (fm == 2) ? "R2" : "R3";
        if (rn == 5'd31 && fm != 0) tag = {tag, "/R6"};

        @(negedge clk);
        chk(in_ready == 1'b1, "R11 idle ready", 64'(in_ready), 64'd1);
        in_insn  = insn;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(undef_o == und, "R8 undef pulse", 64'(undef_o), 64'(und));
        chk(align_fault_o == flt, "R7 align fault", 64'(align_fault_o), 64'(flt));
        chk(mem_req_valid == (!und && !flt), "R10 request issued",
            64'(mem_req_valid), 64'(!und && !flt));
        if (und || flt) begin
            chk(in_ready && !dst_we && !base_we, und ? "R8 quiet" : "R7 quiet",
                {61'd0, in_ready, dst_we, base_we}, 64'd4);
            return;
        end
        repeat ($urandom_range(0, 2)) begin
            chk(mem_req_valid == 1'b1, "R10 request held", 64'(mem_req_valid), 64'd1);
            chk(mem_req_addr == maddr, "R10 address stable", mem_req_addr, maddr);
            @(negedge clk);
        end
        chk(mem_req_addr == maddr, {tag, " address"}, mem_req_addr, maddr);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(!mem_req_valid && mem_rsp_ready, "R11 waiting for response",
            {62'd0, mem_req_valid, mem_rsp_ready}, 64'd1);
        repeat ($urandom_range(0, 2)) begin
            chk(!dst_we && !base_we && !in_ready, "R4 no early write",
                {61'd0, dst_we, base_we, in_ready}, 64'd0);
            @(negedge clk);
        end
        word = $urandom;
        if ($urandom_range(0, 1) == 1) word[31] = 1'b1;
        sx = {{32{word[31]}}, word};
        mem_rsp_data  = word;
        mem_rsp_valid = 1'b1;
        #1;
        chk(dst_we == (rt != 5'd31), "R5 destination enable", 64'(dst_we), 64'(rt != 5'd31));
        if (rt != 5'd31) begin
            chk(dst_idx == rt, "R4 destination index", 64'(dst_idx), 64'(rt));
            chk(dst_data == sx, "R4 sign extension", dst_data, sx);
        end
        exp_bw = wbk && !ovl;
        chk(base_we == exp_bw, ovl ? "R9 suppressed update" : {tag, " base update"},
            64'(base_we), 64'(exp_bw));
        if (exp_bw) begin
            chk(base_data == ea, {tag, " base value"}, base_data, ea);
            chk(base_to_sp == (rn == 5'd31), "R6 stack pointer target",
                64'(base_to_sp), 64'(rn == 5'd31));
            if (rn != 5'd31)
                chk(base_idx == rn, {tag, " base index"}, 64'(base_idx), 64'(rn));
        end
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        if (rt != 5'd31) regs[rt] = sx;
        if (exp_bw) begin
            if (rn == 5'd31) sp_m = ea;
            else regs[rn] = ea;
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) regs[i] = {$urandom, $urandom};
        sp_m = 64'h0000_7fff_0000_1000;
        repeat (3) @(negedge clk);
        chk(in_ready && !mem_req_valid && !undef_o && !align_fault_o && !dst_we && !base_we,
            "R11 reset state",
            {58'd0, in_ready, mem_req_valid, undef_o, align_fault_o, dst_we, base_we},
            64'h20);
        rst_n = 1'b1;

        // Directed corners.
        run_insn(mk_idx(1'b0, 9'h100, 5'd3, 5'd4));     // R1 most negative disp
        run_insn(mk_idx(1'b1, 9'h0ff, 5'd5, 5'd6));     // R2 largest positive disp
        run_insn(mk_sc(12'hfff, 5'd7, 5'd8));           // R3 offset 16380
        run_insn(mk_sc(12'h000, 5'd9, 5'd31));          // R5 zero register
        run_insn(mk_idx(1'b1, 9'h010, 5'd31, 5'd2));    // R6 stack pointer pre-update
        run_insn(mk_idx(1'b0, 9'h003, 5'd31, 5'd2));    // R6 leaves SP misaligned
        run_insn(mk_sc(12'h001, 5'd31, 5'd1));          // R7 fault
        sp_m = 64'h0000_7fff_0000_2000;
        run_insn(mk_idx(1'b0, 9'h008, 5'd12, 5'd12));   // R9 overlap suppressed
        run_insn(mk_idx(1'b1, 9'h1f0, 5'd13, 5'd13));   // R9 overlap suppressed
        run_insn(32'h0000_0000);                        // R8
        run_insn({11'b10111000100, 9'h005, 2'b00, 5'd1, 5'd2});  // R8 bad index bits
        run_insn({11'b10111000100, 9'h005, 2'b10, 5'd1, 5'd2});  // R8 bad index bits

        // Random mix.
        for (int n = 0; n < 600; n++) begin
            logic [4:0]  rn;
            logic [4:0]  rt;
            logic [31:0] w;
            int          k;
            rn = ($urandom_range(0, 3) == 0) ? 5'd31 : 5'($urandom_range(0, 30));
            rt = ($urandom_range(0, 5) == 0) ? rn : 5'($urandom);
            k  = $urandom_range(0, 9);
            if (k < 3)      w = mk_idx(1'b0, 9'($urandom), rn, rt);
            else if (k < 6) w = mk_idx(1'b1, 9'($urandom), rn, rt);
            else if (k < 9) w = mk_sc(12'($urandom), rn, rt);
            else            w = $urandom;
            if ($urandom_range(0, 7) == 0) sp_m = {$urandom, $urandom} & ~64'hf;
            run_insn(w);
        end
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule